// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host end of a link to an 8-bit successive-approximation converter that has a serial address-and-data interface. A single `start` pulse carries the channel, the input mode and the polarity. The block then drops chip select and clocks the converter from a divided system clock. It shifts out the start bit and the channel assignment word, lets the converter settle for one clock, and collects the conversion result MSB first. When the transaction ends, it raises chip select and pulses `done` with the byte.

The block handles both address formats. The short format is a 3-bit word for four-channel parts, and the long format is a 4-bit word for eight-channel parts. It can also stay connected for the seven-bit LSB-first echo that the converter sends after the MSB-first byte. It checks that echo against the byte it already holds and raises `mismatch` if the two disagree. In single-wire mode the converter's data input and output share one wire, so the host stops driving that wire once the address has gone out. The serial clock rate is set per transaction. A zero setting selects a built-in default.

Top module: `adc_serial_host`

## Requirements
- R1: While `rst` is high and in the cycle after it, `adc_cs_n`=1, `adc_sclk`=0, `adc_di_oe`=0, `busy`=0, `done`=0, `result`=0 and `mismatch`=0. This also holds when reset arrives in the middle of a transaction.
- R2: A `start` in idle drops `adc_cs_n`. `adc_di` then carries a high start bit, followed by the assignment word, with each bit stable across a rising `adc_sclk` edge. The word bits, in order, are:
  - single-ended flag: 1 when `cfg_diff`=0;
  - odd/sign bit: `cfg_chan[0]` for single-ended, `cfg_swap` for differential;
  - `cfg_chan[2]` then `cfg_chan[1]` when `cfg_wide`=1, or `cfg_chan[1]` alone when `cfg_wide`=0.
- R3: The high and low phases of `adc_sclk` each last `cfg_half`+1 system cycles. A `cfg_half` of 0 selects `DEF_HALF`+1 cycles; with the default of 499 this is 250 kHz from 250 MHz.
- R4: The host ignores the rising edge that follows the last address bit, because it is the settling slot. The next eight rising edges sample `adc_do` MSB first into `result`.
- R5: With `cfg_check`=1, seven further rising edges sample the echo bits 1 to 7 in that order. `mismatch`=1 exactly when any echo bit differs from the `result` bit with the same index. With `cfg_check`=0 there are no echo clocks and `mismatch`=0. The total number of rising edges is A+10, or A+17 with the echo, where A is 4 (long word) or 3 (short word).
- R6: With `cfg_one_wire`=1, `adc_di_oe` is high through the start bit and the address. It goes low on the falling `adc_sclk` edge after the last address bit. With `cfg_one_wire`=0, `adc_di_oe` stays high while `adc_cs_n` is low, and `adc_di` is 0 after the address.
- R7: `adc_cs_n` rises on the falling edge after the last sampled bit. In that same cycle, `done` is high for exactly one cycle, with `result` and `mismatch` valid. `busy` is high from the cycle after `start` until the block returns to idle.
- R8: Between transactions `adc_cs_n` stays high for at least 2*(half+1) system cycles, even when `start` is held high.
- R9: `start` and every `cfg_*` input are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (taken only when idle) |
| cfg_chan | input | 3 | Channel number, or pair number in bits 2:1 |
| cfg_diff | input | 1 | 1 = differential pair, 0 = single-ended |
| cfg_swap | input | 1 | Differential polarity (odd/sign bit) |
| cfg_wide | input | 1 | 1 = 4-bit word, 0 = 3-bit word |
| cfg_check | input | 1 | Also read and compare the LSB-first echo |
| cfg_one_wire | input | 1 | Release the data line after addressing |
| cfg_half | input | DIV_W | Half-period minus one in system cycles, 0 = default |
| busy | output | 1 | Transaction or chip-select gap in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 8 | Converted byte |
| mismatch | output | 1 | Echo disagreed with the byte |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_di | output | 1 | Address data to the converter |
| adc_di_oe | output | 1 | Output enable for the data line driver |
| adc_do | input | 1 | Serial data from the converter |

## Verification
A wrong edge counter shows in the same transaction, either as a rising-edge count on `adc_sclk` that differs from A+10 or A+17, or as a `result` shifted by one bit position. A divider fault shows within the first serial half period as a wrong high-phase width. In single-wire mode, a missed driver release makes the host read back its own low `adc_di`, so `result` collapses towards zero on the first data bit. Echo comparison errors only become visible at `done`, through `mismatch`. The bench therefore uses echo patterns that flip a single bit at each end of the range.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned TAIL_W  = DATA_W - 1;
    localparam int unsigned IDX_W   = $clog2(DATA_W);
    localparam int unsigned FRAME_W = 5;
    localparam int unsigned EDGE_W  = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_GAP
    } state_e;

    typedef struct packed {
        logic [2:0] chan;
        logic       diff;
        logic       swap;
        logic       wide;
        logic       check;
        logic       one_wire;
    } req_t;

    // start bit first, then the assignment word, zero padded for the short form
    function automatic logic [FRAME_W-1:0] addr_frame(req_t r);
        logic sgl, odd, sel_hi, sel_lo;
        sgl    = ~r.diff;
        odd    = r.diff ? r.swap : r.chan[0];
        sel_hi = r.wide ? r.chan[2] : r.chan[1];
        sel_lo = r.wide ? r.chan[1] : 1'b0;
        return {1'b1, sgl, odd, sel_hi, sel_lo};
    endfunction

    function automatic logic [EDGE_W-1:0] addr_len(req_t r);
        return r.wide ? EDGE_W'(4) : EDGE_W'(3);
    endfunction

    // rising edges in a transaction: start + word + settle + data (+ echo)
    function automatic logic [EDGE_W-1:0] last_edge(req_t r);
        return addr_len(r) + EDGE_W'(2 + DATA_W) + (r.check ? EDGE_W'(TAIL_W) : EDGE_W'(0));
    endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == half) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign tick = run && (cnt_q == half);

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && half != '0) |=> !tick);

endmodule

// File: rtl/adc_addr_tx.sv
module adc_addr_tx #(
    parameter int unsigned FW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [FW-1:0] frame,
    input  logic          shift,
    output logic          bit_o
);

    logic [FW-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= frame;
        end else if (shift) begin
            sh_q <= {sh_q[FW-2:0], 1'b0};
        end
    end

    assign bit_o = sh_q[FW-1];

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (load && frame[FW-1]) |=> bit_o);

endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture #(
    parameter int unsigned W = 8,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          tail_en,
    input  logic [IW-1:0] tail_idx,
    input  logic          bit_in,
    output logic [W-1:0]  data,
    output logic          err
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            data <= '0;
            err  <= 1'b0;
        end else begin
            if (shift_en) begin
                data <= {data[W-2:0], bit_in};
            end
            if (tail_en && (bit_in != data[tail_idx])) begin
                err <= 1'b1;
            end
        end
    end

    // R5
    err_from_tail_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(tail_en));

    // R4
    data_tail_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(shift_en && tail_en));

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int unsigned DIV_W    = 16,
    parameter int unsigned DEF_HALF = 499
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        cfg_chan,
    input  logic              cfg_diff,
    input  logic              cfg_swap,
    input  logic              cfg_wide,
    input  logic              cfg_check,
    input  logic              cfg_one_wire,
    input  logic [DIV_W-1:0]  cfg_half,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              mismatch,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_di,
    output logic              adc_di_oe,
    input  logic              adc_do
);

    localparam logic [EDGE_W-1:0] DATA_END = EDGE_W'(2 + DATA_W);

    state_e              state_q;
    req_t                req_q;
    logic [DIV_W-1:0]    half_q;
    logic [EDGE_W-1:0]   rcnt_q;
    logic                gap_q;
    logic                cs_n_q, sclk_q, di_oe_q, done_q, mism_q;
    logic [DATA_W-1:0]   res_q;

    logic                run, tick, rise, fall, finish;
    logic [EDGE_W-1:0]   alen, lastno, edge_no, tail_pos;
    logic                is_data, is_tail, tx_load;
    logic [DATA_W-1:0]   rx_data;
    logic                rx_err;
    logic                tx_bit;

    assign run     = (state_q != ST_IDLE);
    assign rise    = (state_q == ST_RUN) && tick && !sclk_q;
    assign fall    = (state_q == ST_RUN) && tick && sclk_q;
    assign alen    = addr_len(req_q);
    assign lastno  = last_edge(req_q);
    assign edge_no = rcnt_q + EDGE_W'(1);
    assign finish  = fall && (rcnt_q == lastno);

    assign is_data  = rise && (edge_no >= alen + EDGE_W'(3)) && (edge_no <= alen + DATA_END);
    assign is_tail  = rise && req_q.check && (edge_no > alen + DATA_END);
    assign tail_pos = edge_no - alen - DATA_END;
    assign tx_load  = (state_q == ST_RUN) && (rcnt_q == '0);

    adc_sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .half (half_q),
        .tick (tick)
    );

    adc_addr_tx #(.FW(FRAME_W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .load  (tx_load),
        .frame (addr_frame(req_q)),
        .shift (fall),
        .bit_o (tx_bit)
    );

    adc_rx_capture #(.W(DATA_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .clr      (state_q == ST_IDLE),
        .shift_en (is_data),
        .tail_en  (is_tail),
        .tail_idx (tail_pos[IDX_W-1:0]),
        .bit_in   (adc_do),
        .data     (rx_data),
        .err      (rx_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            half_q  <= '0;
            rcnt_q  <= '0;
            gap_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b0;
            di_oe_q <= 1'b0;
            done_q  <= 1'b0;
            mism_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        req_q   <= '{chan: cfg_chan, diff: cfg_diff, swap: cfg_swap,
                                     wide: cfg_wide, check: cfg_check, one_wire: cfg_one_wire};
                        half_q  <= (cfg_half == '0) ? DIV_W'(DEF_HALF) : cfg_half;
                        rcnt_q  <= '0;
                        cs_n_q  <= 1'b0;
                        di_oe_q <= 1'b1;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        if (!sclk_q) begin
                            rcnt_q <= edge_no;
                        end else if (finish) begin
                            cs_n_q  <= 1'b1;
                            di_oe_q <= 1'b0;
                            done_q  <= 1'b1;
                            res_q   <= rx_data;
                            mism_q  <= rx_err;
                            gap_q   <= 1'b0;
                            state_q <= ST_GAP;
                        end else if (req_q.one_wire && (rcnt_q == alen + EDGE_W'(1))) begin
                            di_oe_q <= 1'b0;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        gap_q <= 1'b1;
                        if (gap_q) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = run;
    assign done      = done_q;
    assign result    = res_q;
    assign mismatch  = mism_q;
    assign adc_cs_n  = cs_n_q;
    assign adc_sclk  = sclk_q;
    assign adc_di    = tx_bit;
    assign adc_di_oe = di_oe_q;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7
    done_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cs_n_q && !$past(cs_n_q)));

    // R6
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_q |-> (!sclk_q && !di_oe_q));

    // R6
    two_wire_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_q && !req_q.one_wire) |-> di_oe_q);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> ($stable(req_q) && $stable(half_q)));

    // R8
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_q) |=> cs_n_q);

endmodule

// File: tb/tb_adc_serial_host.sv
`timescale 1ns/1ps
module tb_adc_serial_host;

    localparam int DIV_W = 16;

    typedef struct packed {
        logic [2:0]  chan;
        logic        diff;
        logic        swap;
        logic        wide;
        logic        check;
        logic        one_wire;
        logic        settle;
        logic [15:0] half;
        logic [7:0]  sample;
        logic [7:0]  flip;
    } vec_t;

    // chan diff swap wide check one_wire settle half sample flip
    localparam vec_t VECS [8] = '{
        '{3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1, 8'hA5, 8'h00},
        '{3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd2, 8'h3C, 8'h00},
        '{3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1, 8'hFF, 8'h00},
        '{3'd6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd3, 8'h81, 8'h10},
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd1, 8'h00, 8'h80},
        '{3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'd2, 8'h5A, 8'h7E},
        '{3'd7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'd1, 8'h01, 8'h02},
        '{3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd1, 8'hC3, 8'h00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] cfg_chan = '0;
    logic cfg_diff = 1'b0, cfg_swap = 1'b0, cfg_wide = 1'b0, cfg_check = 1'b0, cfg_one_wire = 1'b0;
    logic [DIV_W-1:0] cfg_half = '0;
    logic busy, done, mismatch, adc_cs_n, adc_sclk, adc_di, adc_di_oe, adc_do;
    logic [7:0] result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // converter model
    logic       m_do = 1'b0;
    int         m_rises = 0, m_n = 3, m_bits = 0, m_out = 0;
    logic       m_started = 1'b0, m_settle = 1'b0;
    logic [3:0] m_word = '0;
    logic [7:0] m_sample = '0, m_flip = '0;
    logic       m_oe_addr = 1'b1, m_oe_settle = 1'b0, m_di_settle = 1'b0;

    assign adc_do = cfg_one_wire ? (adc_di_oe ? adc_di : m_do) : m_do;

    always @(negedge adc_cs_n) begin
        m_rises = 0; m_started = 1'b0; m_bits = 0; m_word = '0;
        m_out = 0; m_do = 1'b0; m_oe_addr = 1'b1;
    end

    always @(posedge adc_sclk) begin
        if (adc_cs_n == 1'b0) begin
            m_rises++;
            if (!m_started) begin
                m_oe_addr = m_oe_addr & adc_di_oe;
                if (adc_di) m_started = 1'b1;
            end else if (m_bits < m_n) begin
                m_oe_addr = m_oe_addr & adc_di_oe;
                m_word = {m_word[2:0], adc_di};
                m_bits++;
            end else if (m_out == 1) begin
                m_oe_settle = adc_di_oe;
                m_di_settle = adc_di;
            end
        end
    end

    always @(negedge adc_sclk) begin
        if (adc_cs_n == 1'b0 && m_started && m_bits == m_n) begin
            if (m_out == 0)       m_do = m_settle;
            else if (m_out <= 8)  m_do = m_sample[8 - m_out];
            else if (m_out <= 15) m_do = m_sample[m_out - 8] ^ m_flip[m_out - 8];
            else                  m_do = 1'b0;
            m_out++;
        end
    end

    // sclk high phase width in system cycles
    int hi_cnt = 0, last_hi = 0;
    always @(negedge clk) begin
        if (adc_sclk === 1'b1) hi_cnt++;
        else begin
            if (hi_cnt != 0) last_hi = hi_cnt;
            hi_cnt = 0;
        end
    end

    adc_serial_host #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_chan(cfg_chan), .cfg_diff(cfg_diff), .cfg_swap(cfg_swap),
        .cfg_wide(cfg_wide), .cfg_check(cfg_check), .cfg_one_wire(cfg_one_wire),
        .cfg_half(cfg_half), .busy(busy), .done(done), .result(result),
        .mismatch(mismatch), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_di(adc_di), .adc_di_oe(adc_di_oe), .adc_do(adc_do)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_word(input vec_t v);
        logic odd;
        odd = v.diff ? v.swap : v.chan[0];
        if (v.wide) return {~v.diff, odd, v.chan[2], v.chan[1]};
        return {1'b0, ~v.diff, odd, v.chan[1]};
    endfunction

    function automatic int exp_rises(input vec_t v);
        return (v.wide ? 4 : 3) + 10 + (v.check ? 7 : 0);
    endfunction

    task automatic apply(input vec_t v);
        cfg_chan = v.chan; cfg_diff = v.diff; cfg_swap = v.swap; cfg_wide = v.wide;
        cfg_check = v.check; cfg_one_wire = v.one_wire; cfg_half = v.half;
        m_n = v.wide ? 4 : 3; m_sample = v.sample; m_flip = v.flip; m_settle = v.settle;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (done !== 1'b1 && n < 60000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_txn(input vec_t v, input int hi_exp, input string tag);
        logic exp_mm;
        exp_mm = v.check && (v.flip[7:1] != 7'd0);
        chk("R7", {tag, " done seen"}, done, 1);
        chk("R4", {tag, " result"}, result, v.sample);
        chk("R5", {tag, " mismatch"}, mismatch, exp_mm);
        chk("R2", {tag, " address word"}, m_word, exp_word(v));
        chk("R5", {tag, " rising edges"}, m_rises, exp_rises(v));
        chk("R3", {tag, " sclk high width"}, last_hi, hi_exp);
        chk("R6", {tag, " oe through address"}, m_oe_addr, 1);
        chk("R6", {tag, " oe at settle"}, m_oe_settle, !v.one_wire);
        if (!v.one_wire) chk("R6", {tag, " di low after address"}, m_di_settle, 0);
        chk("R7", {tag, " cs high at done"}, adc_cs_n, 1);
        @(negedge clk);
        chk("R7", {tag, " done one cycle"}, done, 0);
    endtask

    task automatic idle_wait();
        int n;
        n = 0;
        while (busy !== 1'b0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..R9 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        vec_t v;
        int cnt;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cs_n in reset", adc_cs_n, 1);
        chk("R1", "sclk in reset", adc_sclk, 0);
        chk("R1", "oe in reset", adc_di_oe, 0);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "done in reset", done, 0);
        chk("R1", "result in reset", result, 0);
        chk("R1", "mismatch in reset", mismatch, 0);
        rst = 1'b0;
        @(negedge clk);

        // table of vectors (R2..R7)
        for (int i = 0; i < 8; i++) begin
            apply(VECS[i]);
            pulse_start();
            chk("R7", $sformatf("vec%0d busy", i), busy, 1);
            wait_done();
            check_txn(VECS[i], int'(VECS[i].half) + 1, $sformatf("vec%0d", i));
            idle_wait();
        end

        // R3 default divider when cfg_half is zero
        v = '{3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 8'h6D, 8'h00};
        apply(v);
        pulse_start();
        wait_done();
        check_txn(v, 500, "default_div");
        idle_wait();

        // R9 start and config ignored while busy
        v = '{3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd2, 8'h96, 8'h00};
        apply(v);
        pulse_start();
        repeat (3) @(negedge clk);
        cfg_chan = 3'd6; cfg_diff = 1'b0; cfg_half = 16'd1; cfg_check = 1'b0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done();
        check_txn(v, 3, "r9_busy");
        repeat (40) @(negedge clk);
        chk("R9", "no second transaction busy", busy, 0);
        chk("R9", "no second transaction cs", adc_cs_n, 1);

        // R8 back-to-back with start held
        v = '{3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd3, 8'h42, 8'h00};
        apply(v);
        pulse_start();
        wait_done();
        chk("R8", "first txn result", result, v.sample);
        start = 1'b1;
        cnt = 0;
        while (adc_cs_n === 1'b1 && cnt < 1000) begin
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        chk("R8", "cs high gap", (cnt >= 8) ? 8 : cnt, 8);
        wait_done();
        chk("R8", "second txn result", result, v.sample);
        idle_wait();

        // R1 reset in the middle of a transaction
        v = VECS[0];
        apply(v);
        pulse_start();
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "mid reset cs_n", adc_cs_n, 1);
        chk("R1", "mid reset sclk", adc_sclk, 0);
        chk("R1", "mid reset oe", adc_di_oe, 0);
        chk("R1", "mid reset busy", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "after reset idle", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule